// File: doc/BRIEF.md
# Section-Based Address Translation Unit

This block maps 32-bit virtual addresses onto physical addresses in fixed 1 MiB regions, using one flat table that lives in memory. The twelve upper bits of the virtual address select one 32-bit table entry. The unit fetches that entry through a single read port whose latency is not fixed. It then checks the entry against the kind of access (data read, data write or instruction fetch) and the requester's privilege. It returns either the physical address or a fault with a two-bit cause. The 20 offset bits always pass through unchanged.

Software sets up the unit through a two-register configuration port. Selector 0 writes the table base, which must be aligned to 16 KiB. Selector 1 writes the enable bit. While the enable bit is clear, every request completes without a table read, and the physical address equals the virtual address.

The control is a four-state machine with a single walk outstanding:
- **IDLE**: the only state where `req_ready` is high. An accepted request goes to **ISSUE** when translation is enabled, or straight to **DONE** (bypass) when it is not.
- **ISSUE**: holds the table read strobe for one cycle, then moves to **WAIT**.
- **WAIT**: stays until the response strobe arrives, then moves to **DONE** with the checked result.
- **DONE**: pulses `done` for one cycle and returns to **IDLE**.

Top module: `sect_xlate`

## Requirements
- R1: While the enable bit is 0, each accepted request completes with `res_paddr` equal to `req_vaddr`, `res_fault`=0 and `res_cause`=00, and issues no table read.
- R2: When enabled, each request issues exactly one table read, one cycle long, at address {base[31:14], vaddr[31:20], 2'b00}.
- R3: An entry that passes every check gives `res_fault`=0, `res_cause`=00 and `res_paddr` = {entry[31:20], vaddr[19:0]}. Entry bits [19:4] are ignored.
- R4: An entry with bit 0 (valid) clear gives a fault with cause 01 (translation).
- R5: An entry with bit 1 (privileged-only) set gives a fault with cause 10 (permission) for any access kind when `req_priv`=0. When `req_priv`=1 it has no effect.
- R6: An entry with bit 2 (execute-never) set gives a fault with cause 11 (execute) for an instruction fetch (`req_kind`=10). Data reads (00) and writes (01) are unaffected.
- R7: An entry with bit 3 (read-only) set gives a fault with cause 10 for a data write (`req_kind`=01). Reads and fetches are unaffected.
- R8: When several checks fail, the reported cause follows this order: invalid, then privilege, then execute-never, then read-only.
- R9: `req_ready` is high only in IDLE. `done` is high for exactly one cycle per accepted request, and `req_ready` returns the cycle after `done`.
- R10: After reset the unit is disabled with base 0. A write with selector 0 keeps only bits [31:14] of the data as the base. A write with selector 1 takes bit 0 as the enable.
- R11: A faulting result drives `res_paddr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: table base, 1: enable |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch (11 treated as read) |
| req_priv | input | 1 | Requester is privileged |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 32 | Table entry address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table entry |
| done | output | 1 | Result valid, one cycle |
| res_paddr | output | 32 | Physical address |
| res_fault | output | 1 | Access faulted |
| res_cause | output | 2 | 01 translation, 10 permission, 11 execute, 00 none |

## Verification
The bench sweeps 256 table indices. The entry flag bits are taken from the index, so all sixteen flag combinations are tried with each access kind and each privilege level. This separates the four checks from each other and confirms their priority order. Further requests at the extreme indices (0 and 0xFFF) and a varied read latency test the index and offset wiring and the wait for the response. Requests made before enabling and after disabling tell the bypass path apart from the walk, and a base written with nonzero low bits shows that those bits are dropped.

// File: rtl/xl_pkg.sv
package xl_pkg;

    typedef enum logic [1:0] {
        K_READ  = 2'b00,
        K_WRITE = 2'b01,
        K_FETCH = 2'b10,
        K_RSVD  = 2'b11
    } xl_kind_e;

    typedef enum logic [1:0] {
        C_NONE  = 2'b00,
        C_XLATE = 2'b01,
        C_PERM  = 2'b10,
        C_EXEC  = 2'b11
    } xl_cause_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_DONE
    } xl_state_e;

    localparam int unsigned F_VALID = 0;
    localparam int unsigned F_PRIV  = 1;
    localparam int unsigned F_XN    = 2;
    localparam int unsigned F_RO    = 3;

endpackage

// File: rtl/xl_cfg_regs.sv
module xl_cfg_regs #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ALIGN_W = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic                        cfg_sel,
    input  logic [ADDR_W-1:0]           cfg_wdata,
    output logic [ADDR_W-ALIGN_W-1:0]   base_hi,
    output logic                        xl_en
);
    logic unused_low;
    assign unused_low = ^{cfg_wdata[ALIGN_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            xl_en   <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel) xl_en   <= cfg_wdata[0];
            else         base_hi <= cfg_wdata[ADDR_W-1:ALIGN_W];
        end
    end
endmodule

// File: rtl/xl_perm_check.sv
module xl_perm_check
    import xl_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 20
) (
    input  logic [31:0]        entry,
    input  logic [1:0]         kind,
    input  logic               priv,
    input  logic [ADDR_W-1:0]  vaddr,
    output logic [ADDR_W-1:0]  paddr,
    output logic               fault,
    output logic [1:0]         cause
);
    logic unused_mid;
    assign unused_mid = ^{entry[OFFS_W-1:4], vaddr[ADDR_W-1:OFFS_W]};

    xl_cause_e c;

    always_comb begin
        if (!entry[F_VALID])                      c = C_XLATE;
        else if (entry[F_PRIV] && !priv)          c = C_PERM;
        else if (entry[F_XN] && kind == K_FETCH)  c = C_EXEC;
        else if (entry[F_RO] && kind == K_WRITE)  c = C_PERM;
        else                                      c = C_NONE;
    end

    assign fault = (c != C_NONE);
    assign cause = c;
    assign paddr = fault ? '0 : {entry[31:OFFS_W], vaddr[OFFS_W-1:0]};
endmodule

// File: rtl/xl_walk_fsm.sv
module xl_walk_fsm
    import xl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFFS_W  = 20,
    parameter int unsigned ALIGN_W = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       xl_en,
    input  logic [ADDR_W-ALIGN_W-1:0]  base_hi,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_vaddr,
    input  logic [1:0]                 req_kind,
    input  logic                       req_priv,
    output logic                       mem_rd_en,
    output logic [ADDR_W-1:0]          mem_rd_addr,
    input  logic                       mem_rsp_valid,
    input  logic [31:0]                mem_rsp_data,
    output logic                       done,
    output logic [ADDR_W-1:0]          res_paddr,
    output logic                       res_fault,
    output logic [1:0]                 res_cause
);
    localparam int unsigned IDX_W = ADDR_W - OFFS_W;

    xl_state_e state, state_nx;
    logic [ADDR_W-1:0] va_q;
    logic [1:0]        kind_q;
    logic              priv_q;
    logic [ADDR_W-1:0] ent_addr_q;

    logic [ADDR_W-1:0] chk_paddr;
    logic              chk_fault;
    logic [1:0]        chk_cause;

    logic accept;
    assign accept = (state == S_IDLE) && req_valid;

    xl_perm_check #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_perm (
        .entry (mem_rsp_data),
        .kind  (kind_q),
        .priv  (priv_q),
        .vaddr (va_q),
        .paddr (chk_paddr),
        .fault (chk_fault),
        .cause (chk_cause)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = xl_en ? S_ISSUE : S_DONE;
            S_ISSUE: state_nx = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_rd_en = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_IDLE:  req_ready = 1'b1;
            S_ISSUE: mem_rd_en = 1'b1;
            S_WAIT:  ;
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end
    assign mem_rd_addr = ent_addr_q;

    // request capture and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q       <= '0;
            kind_q     <= K_READ;
            priv_q     <= 1'b0;
            ent_addr_q <= '0;
            res_paddr  <= '0;
            res_fault  <= 1'b0;
            res_cause  <= C_NONE;
        end else begin
            if (accept) begin
                va_q       <= req_vaddr;
                kind_q     <= req_kind;
                priv_q     <= req_priv;
                ent_addr_q <= {base_hi, req_vaddr[ADDR_W-1 -: IDX_W], 2'b00};
                if (!xl_en) begin
                    res_paddr <= req_vaddr;
                    res_fault <= 1'b0;
                    res_cause <= C_NONE;
                end
            end
            if (state == S_WAIT && mem_rsp_valid) begin
                res_paddr <= chk_paddr;
                res_fault <= chk_fault;
                res_cause <= chk_cause;
            end
        end
    end
endmodule

// File: rtl/sect_xlate.sv
module sect_xlate #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              done,
    output logic [ADDR_W-1:0] res_paddr,
    output logic              res_fault,
    output logic [1:0]        res_cause
);
    localparam int unsigned ALIGN_W = ADDR_W - OFFS_W + 2;

    logic [ADDR_W-ALIGN_W-1:0] base_hi;
    logic                      xl_en;

    xl_cfg_regs #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_hi   (base_hi),
        .xl_en     (xl_en)
    );

    xl_walk_fsm #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .ALIGN_W(ALIGN_W)) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .xl_en         (xl_en),
        .base_hi       (base_hi),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_kind      (req_kind),
        .req_priv      (req_priv),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .res_paddr     (res_paddr),
        .res_fault     (res_fault),
        .res_cause     (res_cause)
    );
endmodule

// File: rtl/xl_checker.sv
module xl_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              done,
    input logic [ADDR_W-1:0] res_paddr,
    input logic              res_fault,
    input logic [1:0]        res_cause
);
    localparam int unsigned IDX_W = ADDR_W - OFFS_W;

    logic [ADDR_W-1:0] va_seen;
    always_ff @(posedge clk) begin
        if (!rst_n)                      va_seen <= '0;
        else if (req_valid && req_ready) va_seen <= req_vaddr;
    end

    // R2: one-cycle read strobe, index bits and word alignment
    p_rd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    p_rd_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr[IDX_W+1:2] == va_seen[ADDR_W-1 -: IDX_W]
                       && mem_rd_addr[1:0] == 2'b00));
    // R3: offset passes through on success
    p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_fault) |-> (res_paddr[OFFS_W-1:0] == va_seen[OFFS_W-1:0]
                                  && res_cause == 2'b00));
    // R9: done is a single pulse and not seen while ready
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
    p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, req_ready, mem_rd_en}));
    // R11: a fault carries a nonzero cause and a zero address
    p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault) |-> (res_cause != 2'b00 && res_paddr == '0));
endmodule

bind sect_xlate xl_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .done        (done),
    .res_paddr   (res_paddr),
    .res_fault   (res_fault),
    .res_cause   (res_cause)
);

// File: tb/tb_sect_xlate.sv
module tb_sect_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, res_fault;
    logic [31:0] res_paddr;
    logic [1:0]  res_cause;

    int errors = 0, checks = 0, reads = 0;
    logic [31:0] cur_base = '0;
    logic [11:0] cur_idx = '0;

    always #5 clk = ~clk;

    sect_xlate dut (.*);

    function automatic logic [31:0] tbl(input logic [11:0] idx);
        return {idx ^ 12'hA5C, 16'h0000, idx[3:0]};
    endfunction

    task automatic chk(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // table memory model: latency 1..4 cycles, address checked (R2)
    initial forever begin
        @(negedge clk);
        if (mem_rd_en) begin
            automatic logic [31:0] a = mem_rd_addr;
            automatic int lat = int'(a[3:2]) + 1;
            reads++;
            chk("R2 entry addr", a == {cur_base[31:14], cur_idx, 2'b00},
                {32'h0, a}, {32'h0, cur_base[31:14], cur_idx, 2'b00});
            repeat (lat) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = tbl(a[13:2]);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
        end
    end

    task automatic cfg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // issue one request, wait for done, return results sampled at negedge
    task automatic xl(input logic [31:0] va, input logic [1:0] k, input logic p,
                      output logic [31:0] pa, output logic f, output logic [1:0] c);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_idx = va[31:20];
        req_valid = 1'b1; req_vaddr = va; req_kind = k; req_priv = p;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 100) begin @(negedge clk); n++; end
        chk("R9 done seen", done, {63'h0, done}, 64'h1);
        pa = res_paddr; f = res_fault; c = res_cause;
        @(negedge clk);
        chk("R9 single done/ready", !done && req_ready, {62'h0, done, req_ready}, 64'h1);
    endtask

    task automatic expect_walk(input logic [31:0] va, input logic [1:0] k, input logic p);
        logic [31:0] e, pa, epa;
        logic [1:0]  ec, c;
        logic        f;
        e = tbl(va[31:20]);
        if (!e[0])                  ec = 2'b01;   // R4, R8 highest
        else if (e[1] && !p)        ec = 2'b10;   // R5
        else if (e[2] && k == 2'b10) ec = 2'b11;  // R6
        else if (e[3] && k == 2'b01) ec = 2'b10;  // R7
        else                        ec = 2'b00;
        epa = (ec == 2'b00) ? {e[31:20], va[19:0]} : 32'h0;   // R3, R11
        xl(va, k, p, pa, f, c);
        chk("R3-R8 cause", c == ec && f == (ec != 2'b00), {31'h0, f, 30'h0, c},
            {31'h0, ec != 2'b00, 30'h0, ec});
        chk("R3 R11 paddr", pa == epa, {32'h0, pa}, {32'h0, epa});
    endtask

    task automatic expect_bypass(input logic [31:0] va, input logic [1:0] k, input logic p);
        logic [31:0] pa; logic f; logic [1:0] c; int r0;
        r0 = reads;
        xl(va, k, p, pa, f, c);
        chk("R1 bypass", pa == va && !f && c == 2'b00 && reads == r0,
            {pa, 29'h0, f, c}, {va, 32'h0});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 R10 reset", req_ready && !done && !mem_rd_en, {61'h0, req_ready, done, mem_rd_en}, 64'h4);

        // R10: disabled after reset; R1 bypass for all kinds
        for (int k = 0; k < 3; k++) begin
            expect_bypass(32'hFFF0_0001 ^ (32'(k) << 24), 2'(k), k[0]);
            expect_bypass(32'h00AA_0F3C, 2'(k), 1'b0);
        end

        // R10: low base bits dropped
        cfg(1'b0, 32'h0012_7FFF);
        cur_base = 32'h0012_4000;
        cfg(1'b1, 32'h0000_0001);

        // sweep: all flag combinations x kinds x privilege (R3-R8, R11)
        for (int i = 0; i < 256; i++)
            for (int k = 0; k < 3; k++)
                for (int p = 0; p < 2; p++)
                    expect_walk({12'(i * 16 + i / 16), 8'(i), 12'h3C5}, 2'(k), p[0]);

        // extreme indices and offsets
        expect_walk(32'hFFFF_FFFF, 2'b00, 1'b1);
        expect_walk(32'h0000_0000, 2'b01, 1'b1);
        expect_walk(32'h00AA_0F3C, 2'b10, 1'b1);
        expect_walk(32'hFFF0_0000, 2'b10, 1'b0);

        // new base, then disable again (R10, R1)
        cfg(1'b0, 32'hFFFF_C000);
        cur_base = 32'hFFFF_C000;
        expect_walk(32'h1234_5678, 2'b00, 1'b1);
        expect_walk(32'hABCF_FFFF, 2'b01, 1'b0);
        cfg(1'b1, 32'hFFFF_FFFE);
        expect_bypass(32'hDEAD_BEEF, 2'b10, 1'b0);
        expect_bypass(32'h0001_0000, 2'b01, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule